// File: doc/BRIEF.md
# Priority Interrupt Controller with Event Codes

The controller gathers interrupt requests from 22 on-chip sources and from one external 4-bit request level. It works out which pending request has the highest priority and hands that request's priority level and 12-bit event code to the CPU. Priorities are not stored per source. They sit in packed 4-bit fields of three priority registers, and a group of related sources shares one field. On-chip sources can be masked one by one through a 32-bit mask that has a separate set address and a separate clear address.

The CPU supplies its current interrupt mask level as an input. A request reaches the CPU only when its priority is strictly above that level. The result is registered, so the CPU sees a stable level and code from a flop. Configuration uses a single-cycle write bus and a registered read bus. Fetching the vector and entering the exception are done elsewhere.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every priority field and every mask bit is 0. The output shows no request: `irq_valid`=0, `irq_level`=0, `irq_code`=0. Whenever `irq_valid` is 0, level and code read 0.
- R2: A write with `wr_en`=1 at address 0 stores `wdata[15:0]` as priority word A. Address 1 stores `wdata[15:4]` as priority word B, whose bits 3:0 always read 0. Address 2 stores all 32 bits as the extended priority word. `rdata` shows the register selected by `addr` one cycle after `addr` is applied, and unused upper bits read 0.
- R3: Priority word A gives bits 15:12 to timer 0 (source 0), bits 11:8 to timer 1 (source 1), bits 7:4 to the timer 2 group (sources 2 and 3) and bits 3:0 to the clock group (sources 4, 5 and 6). Priority word B gives bits 15:12 to the watchdog (source 7), bits 11:8 to the refresh group (sources 8 and 9) and bits 7:4 to the serial group (sources 10 to 13). Extended source j (source 14+j, j=0..7) uses bits 4j+3:4j of the extended word. Every member of a group takes its group's field.
- R4: Event codes are fixed, in hex: sources 0 to 6 are 400, 420, 440, 460, 480, 4A0, 4C0. Source 7 is 560. Sources 8 and 9 are 580 and 5A0. Sources 10 to 13 are 4E0, 500, 520, 540. Extended source j is A00+20·j. Every code is a multiple of 0x20.
- R5: `ext_lvl` value k from 0 to 14 is a request with priority 15−k and event code 0x200+0x20·k. The value 15 means no external request.
- R6: A write at address 3 sets the mask bits that are 1 in `wdata`. A write at address 4 clears the mask bits that are 1 in `wdata`. Both addresses read back the mask. Mask bit i set blocks on-chip source i.
- R7: The pending unmasked request with the highest priority wins. A priority of 0 never wins. On a tie the external request wins over on-chip sources, and a lower-numbered source wins over a higher-numbered one.
- R8: A winner is forwarded only when its priority is strictly greater than `cpu_mask`.
- R9: The outputs reflect the request inputs and `cpu_mask` one clock edge after they are applied. A register write takes effect on the outputs one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_req | input | 22 | On-chip request lines, bit i = source i |
| ext_lvl | input | 4 | External request level, 15 = none |
| cpu_mask | input | 4 | CPU current interrupt mask level |
| irq_valid | output | 1 | A request is forwarded |
| irq_level | output | 4 | Priority of the forwarded request |
| irq_code | output | 12 | Event code of the forwarded request |

## Verification
Changes to requests and to `cpu_mask` show on the outputs after one rising edge. A register write needs two edges: one to store the value and one to register the resolved result. A read shows on `rdata` one edge after `addr` is applied. The bench drives its inputs at falling edges and waits two rising edges before it compares the forwarded request, which covers both paths. A dedicated scenario samples just before and just after the single edge to pin the one-cycle request latency.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int PRIO_W   = 4;
    localparam int CODE_W   = 12;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int BASE_SRC = 14;
    localparam int EXT_SRC  = 8;
    localparam int NUM_SRC  = BASE_SRC + EXT_SRC;
    localparam int XPRIO_W  = PRIO_W * EXT_SRC;
    localparam int MASK_W   = DATA_W;
    localparam int LVL_NONE = (1 << PRIO_W) - 1;

    localparam logic [ADDR_W-1:0] A_PRIO_A   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRIO_B   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PRIO_X   = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK_SET = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 3'd4;

    typedef struct packed {
        logic [15:0]         pa;
        logic [11:0]         pb;
        logic [XPRIO_W-1:0]  px;
        logic [MASK_W-1:0]   mk;
        logic [DATA_W-1:0]   rd;
    } regs_t;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] level;
        logic [CODE_W-1:0] code;
    } out_t;

    // Priority field of a source; grouped sources share one field.
    function automatic logic [PRIO_W-1:0] src_prio(
        input int i, input logic [15:0] pa, input logic [11:0] pb,
        input logic [XPRIO_W-1:0] px);
        if (i == 0)                 return pa[15:12];
        else if (i == 1)            return pa[11:8];
        else if (i <= 3)            return pa[7:4];
        else if (i <= 6)            return pa[3:0];
        else if (i == 7)            return pb[11:8];
        else if (i <= 9)            return pb[7:4];
        else if (i < BASE_SRC)      return pb[3:0];
        else                        return px[PRIO_W*(i-BASE_SRC) +: PRIO_W];
    endfunction

    // Fixed event code of a source.
    function automatic logic [CODE_W-1:0] src_code(input int i);
        logic [CODE_W-1:0] c;
        if (i <= 6)            c = CODE_W'(12'h400 + 12'h020 * i);
        else if (i == 7)       c = 12'h560;
        else if (i <= 9)       c = CODE_W'(12'h580 + 12'h020 * (i - 8));
        else if (i < BASE_SRC) c = CODE_W'(12'h4E0 + 12'h020 * (i - 10));
        else                   c = CODE_W'(12'hA00 + 12'h020 * (i - BASE_SRC));
        return c;
    endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [15:0]          prio_a,
    output logic [11:0]          prio_b,
    output logic [XPRIO_W-1:0]   prio_x,
    output logic [NUM_SRC-1:0]   mask
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                A_PRIO_A:   r_d.pa = wdata[15:0];
                A_PRIO_B:   r_d.pb = wdata[15:4];
                A_PRIO_X:   r_d.px = wdata[XPRIO_W-1:0];
                A_MASK_SET: r_d.mk = r_q.mk | wdata[MASK_W-1:0];
                A_MASK_CLR: r_d.mk = r_q.mk & ~wdata[MASK_W-1:0];
                default: ;
            endcase
        end
        case (addr)
            A_PRIO_A:   r_d.rd = DATA_W'(r_q.pa);
            A_PRIO_B:   r_d.rd = DATA_W'({r_q.pb, 4'b0000});
            A_PRIO_X:   r_d.rd = DATA_W'(r_q.px);
            A_MASK_SET,
            A_MASK_CLR: r_d.rd = DATA_W'(r_q.mk);
            default:    r_d.rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata  = r_q.rd;
    assign prio_a = r_q.pa;
    assign prio_b = r_q.pb;
    assign prio_x = r_q.px;
    assign mask   = r_q.mk[NUM_SRC-1:0];
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_prio_pkg::*;
(
    input  logic [NUM_SRC-1:0]   src_req,
    input  logic [PRIO_W-1:0]    ext_lvl,
    input  logic [PRIO_W-1:0]    cpu_mask,
    input  logic [15:0]          prio_a,
    input  logic [11:0]          prio_b,
    input  logic [XPRIO_W-1:0]   prio_x,
    input  logic [NUM_SRC-1:0]   mask,
    output logic                 hit,
    output logic [PRIO_W-1:0]    level,
    output logic [CODE_W-1:0]    code
);
    logic [PRIO_W-1:0] eff [NUM_SRC];

    // Effective priority per source: 0 when idle or masked.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_eff
        assign eff[g] = (src_req[g] && !mask[g])
                      ? src_prio(g, prio_a, prio_b, prio_x) : '0;
    end

    logic [PRIO_W-1:0] best_p;
    logic [CODE_W-1:0] best_c;

    always_comb begin
        // External request is considered first, so it wins ties.
        if (ext_lvl != PRIO_W'(LVL_NONE)) begin
            best_p = PRIO_W'(LVL_NONE) - ext_lvl;
            best_c = CODE_W'(12'h200) + {3'b000, ext_lvl, 5'b00000};
        end else begin
            best_p = '0;
            best_c = '0;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (eff[i] > best_p) begin
                best_p = eff[i];
                best_c = src_code(i);
            end
        end
        hit   = best_p > cpu_mask;
        level = hit ? best_p : '0;
        code  = hit ? best_c : '0;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [NUM_SRC-1:0]   src_req,
    input  logic [PRIO_W-1:0]    ext_lvl,
    input  logic [PRIO_W-1:0]    cpu_mask,
    output logic                 irq_valid,
    output logic [PRIO_W-1:0]    irq_level,
    output logic [CODE_W-1:0]    irq_code
);
    logic [15:0]         prio_a_w;
    logic [11:0]         prio_b_w;
    logic [XPRIO_W-1:0]  prio_x_w;
    logic [NUM_SRC-1:0]  mask_w;
    logic                hit_w;
    logic [PRIO_W-1:0]   level_w;
    logic [CODE_W-1:0]   code_w;

    irq_prio_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .prio_a(prio_a_w),
        .prio_b(prio_b_w), .prio_x(prio_x_w), .mask(mask_w)
    );

    irq_prio_resolve u_res (
        .src_req(src_req), .ext_lvl(ext_lvl), .cpu_mask(cpu_mask),
        .prio_a(prio_a_w), .prio_b(prio_b_w), .prio_x(prio_x_w),
        .mask(mask_w), .hit(hit_w), .level(level_w), .code(code_w)
    );

    out_t o_d, o_q;

    always_comb begin
        o_d.valid = hit_w;
        o_d.level = level_w;
        o_d.code  = code_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_valid = o_q.valid;
    assign irq_level = o_q.level;
    assign irq_code  = o_q.code;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic [NUM_SRC-1:0]   src_req,
    input logic [PRIO_W-1:0]    ext_lvl,
    input logic [PRIO_W-1:0]    cpu_mask,
    input logic                 irq_valid,
    input logic [PRIO_W-1:0]    irq_level,
    input logic [CODE_W-1:0]    irq_code,
    input logic [NUM_SRC-1:0]   mask_q
);
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_level == '0 && irq_code == '0));

    a_r8_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq_level > $past(cpu_mask));

    a_r4_code_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> irq_code[4:0] == 5'b00000);

    a_r9_no_req_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == '0 && ext_lvl == PRIO_W'(LVL_NONE)) |=> !irq_valid);

    a_r5_ext_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == '0 && ext_lvl != PRIO_W'(LVL_NONE)
         && (PRIO_W'(LVL_NONE) - ext_lvl) > cpu_mask)
        |=> (irq_valid && irq_code == (CODE_W'(12'h200)
             + {3'b000, $past(ext_lvl), 5'b00000})));

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MASK_CLR) |=> (mask_q & $past(wdata[NUM_SRC-1:0])) == '0);

    a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MASK_SET)
        |=> (mask_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0]));
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .src_req(src_req), .ext_lvl(ext_lvl), .cpu_mask(cpu_mask),
    .irq_valid(irq_valid), .irq_level(irq_level), .irq_code(irq_code),
    .mask_q(mask_w)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [21:0] src_req = '0;
    logic [3:0]  ext_lvl = 4'hF;
    logic [3:0]  cpu_mask = '0;
    logic        irq_valid;
    logic [3:0]  irq_level;
    logic [11:0] irq_code;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_req(src_req), .ext_lvl(ext_lvl),
        .cpu_mask(cpu_mask), .irq_valid(irq_valid), .irq_level(irq_level),
        .irq_code(irq_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic v, input logic [3:0] l,
                             input logic [11:0] c);
        check({req, " valid"}, 32'(irq_valid), 32'(v));
        check({req, " level"}, 32'(irq_level), 32'(l));
        check({req, " code"},  32'(irq_code),  32'(c));
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); addr = a;
        @(negedge clk); d = rdata;
    endtask

    task automatic apply(input logic [21:0] r, input logic [3:0] e, input logic [3:0] m);
        @(negedge clk); src_req = r; ext_lvl = e; cpu_mask = m;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    // Expected values from the requirements, with word A=5678, B=9AB0, X=87654321.
    function automatic logic [3:0] exp_lvl(input int i);
        if (i == 0) return 4'h5;
        if (i == 1) return 4'h6;
        if (i <= 3) return 4'h7;
        if (i <= 6) return 4'h8;
        if (i == 7) return 4'h9;
        if (i <= 9) return 4'hA;
        if (i <= 13) return 4'hB;
        return 4'(i - 13);
    endfunction

    function automatic logic [11:0] exp_code(input int i);
        logic [11:0] t [14] = '{12'h400, 12'h420, 12'h440, 12'h460, 12'h480,
                                12'h4A0, 12'h4C0, 12'h560, 12'h580, 12'h5A0,
                                12'h4E0, 12'h500, 12'h520, 12'h540};
        if (i < 14) return t[i];
        return 12'hA00 + 12'(32 * (i - 14));
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        check_out("R1 reset", 1'b0, 4'h0, 12'h000);
        for (int a = 0; a < 5; a++) begin
            bus_rd(3'(a), d);
            check("R1 reset register", d, 32'h0);
        end
        apply(22'h000001, 4'hF, 4'h0);
        check_out("R1 zero priority blocks", 1'b0, 4'h0, 12'h000);
        apply('0, 4'hF, 4'h0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        bus_wr(3'd0, 32'hABCD5678);
        bus_wr(3'd1, 32'h12349ABF);
        bus_wr(3'd2, 32'h87654321);
        bus_rd(3'd0, d); check("R2 word A readback", d, 32'h00005678);
        bus_rd(3'd1, d); check("R2 word B readback", d, 32'h00009AB0);
        bus_rd(3'd2, d); check("R2 extended readback", d, 32'h87654321);
    endtask

    task automatic t_fields;
        for (int i = 0; i < 22; i++) begin
            apply(22'(1) << i, 4'hF, 4'h0);
            check_out($sformatf("R3 R4 source %0d", i), 1'b1, exp_lvl(i), exp_code(i));
        end
        apply('0, 4'hF, 4'h0);
    endtask

    task automatic t_ext;
        apply('0, 4'd0, 4'h0);  check_out("R5 ext level 0", 1'b1, 4'hF, 12'h200);
        apply('0, 4'd7, 4'h0);  check_out("R5 ext level 7", 1'b1, 4'h8, 12'h2E0);
        apply('0, 4'd14, 4'h0); check_out("R5 ext level 14", 1'b1, 4'h1, 12'h3C0);
        apply('0, 4'd15, 4'h0); check_out("R5 ext none", 1'b0, 4'h0, 12'h000);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        bus_wr(3'd3, 32'h00000001);
        bus_wr(3'd3, 32'h00000100);
        bus_rd(3'd3, d); check("R6 mask read at set", d, 32'h00000101);
        bus_rd(3'd4, d); check("R6 mask read at clear", d, 32'h00000101);
        apply(22'h000001, 4'hF, 4'h0);
        check_out("R6 masked source", 1'b0, 4'h0, 12'h000);
        apply(22'h000003, 4'hF, 4'h0);
        check_out("R6 masked source skipped", 1'b1, 4'h6, 12'h420);
        bus_wr(3'd4, 32'h00000001);
        bus_rd(3'd4, d); check("R6 mask after clear", d, 32'h00000100);
        apply(22'h000001, 4'hF, 4'h0);
        check_out("R6 unmasked source", 1'b1, 4'h5, 12'h400);
        bus_wr(3'd4, 32'hFFFFFFFF);
        apply('0, 4'hF, 4'h0);
    endtask

    task automatic t_arb;
        apply(22'h000011, 4'hF, 4'h0);
        check_out("R7 higher priority wins", 1'b1, 4'h8, 12'h480);
        apply(22'h000070, 4'hF, 4'h0);
        check_out("R7 group tie lowest index", 1'b1, 4'h8, 12'h480);
        apply(22'h002080, 4'hF, 4'h0);
        check_out("R7 serial over watchdog", 1'b1, 4'hB, 12'h540);
        apply(22'h000010, 4'd7, 4'h0);
        check_out("R7 external wins tie", 1'b1, 4'h8, 12'h2E0);
        bus_wr(3'd0, 32'h00005555);
        apply(22'h000003, 4'hF, 4'h0);
        check_out("R7 tie lower source", 1'b1, 4'h5, 12'h400);
        bus_wr(3'd0, 32'h00000678);
        apply(22'h000001, 4'hF, 4'h0);
        check_out("R7 priority zero never wins", 1'b0, 4'h0, 12'h000);
        bus_wr(3'd0, 32'h00005678);
        apply('0, 4'hF, 4'h0);
    endtask

    task automatic t_cpumask;
        apply(22'h000010, 4'hF, 4'h8);
        check_out("R8 equal to mask blocked", 1'b0, 4'h0, 12'h000);
        apply(22'h000010, 4'hF, 4'h7);
        check_out("R8 above mask forwarded", 1'b1, 4'h8, 12'h480);
        apply('0, 4'd0, 4'hE);
        check_out("R8 ext above mask", 1'b1, 4'hF, 12'h200);
        apply('0, 4'hF, 4'h0);
    endtask

    task automatic t_latency;
        @(negedge clk); src_req = 22'h000002;
        #1 check("R9 before edge", 32'(irq_valid), 32'h0);
        @(posedge clk); #1;
        check_out("R9 one edge later", 1'b1, 4'h6, 12'h420);
        @(negedge clk); src_req = '0;
        @(posedge clk); #1;
        check("R9 release one edge later", 32'(irq_valid), 32'h0);
        @(negedge clk); wr_en = 1'b1; addr = 3'd3; wdata = 32'h00000002;
        src_req = 22'h000002;
        @(posedge clk); #1;
        check("R9 write not yet visible", 32'(irq_valid), 32'h1);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #1;
        check("R9 mask visible next edge", 32'(irq_valid), 32'h0);
        @(negedge clk); src_req = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_fields;
        t_ext;
        t_mask;
        t_arb;
        t_cpumask;
        t_latency;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule